// File: doc/BRIEF.md
# Low-Power Mode and Wake Controller

This block sequences the low-power states of a small 8-bit microcontroller core. It watches the core's instruction stream for one-byte power opcodes. Two of them stop the core: one only gates the control clock, the other also asks the oscillator to stop. Two others put port groups into high impedance, and one more cancels that. A halt state and a float state can be held together, which gives six software power-down combinations. A hardware standby pin gives a seventh mode that stops the oscillator and tri-states every pin group.

While the core sleeps, a low level on the active-low interrupt pin or the active-low reset pin restarts the oscillator. The wake only counts if that level is still low after a programmable number of address-latch pulses. The block then tells the core which way to restart: reset to address 0, take the interrupt vector at address 3, or carry on with the instruction after the power-down opcode. The three pins are brought into the clock domain through a synchronizer. All outputs are registered.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: After reset the controller gives cpu_clk_en=1, osc_stop_req=0, float_grp=0 and wake_pulse=0.
- R2: In run state, opcode 01h clears cpu_clk_en and keeps osc_stop_req at 0. Opcode 82h clears cpu_clk_en and sets osc_stop_req.
- R3: While the core is halted, further opcodes on the instruction stream have no effect on any output.
- R4: Opcode A2h floats port groups. float_grp bit 0 is port 1, bit 1 is port 2 bits 4-7, bit 2 is port 2 bits 0-3 and bit 3 is the bus. With ext_rom=0 the result is 0x00F; with ext_rom=1 it is 0x003.
- R5: Opcode C2h floats the output pins. Bits 4..9 are ALE, PSEN, PROG, WR, RD and the T0 clock output. With ext_rom=0 the result is 0x3FF; with ext_rom=1 the memory interface (bits 2, 3, 4, 5) keeps running, which gives 0x3C3.
- R6: The cancel opcode (CANCEL_OP, default E2h) clears float_grp. A synchronized low on int_n or ext_reset_n also clears float_grp.
- R7: During a halt, a low wake pin deasserts osc_stop_req at once. The wake only takes effect once that pin has stayed low through ALE_QUAL (default 2) ale_tick pulses. If the pin goes high earlier, the count is cleared and the block stays halted.
- R8: A qualified interrupt-pin wake gives a one-cycle wake_pulse and sets cpu_clk_en to 1. wake_kind=2 (vector 3) when int_en=1 and in_isr=0; otherwise wake_kind=3 (resume).
- R9: A qualified reset-pin wake gives wake_kind=1 (address 0) and wins over the interrupt pin. After an oscillator-stop halt or standby, it also waits until osc_stable=1.
- R10: standby_n low gives float_grp=0x3FF, osc_stop_req=1 and cpu_clk_en=0. If standby_n returns high while both wake pins are high, the core resumes at once with wake_kind=3.
- R11: If standby_n returns high while a wake pin is low, the wake goes through the same ALE qualification as a software halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | instr_byte holds an executed opcode this cycle |
| instr_byte | input | 8 | Opcode from the core |
| ext_rom | input | 1 | 1 = program fetched from external memory |
| int_en | input | 1 | Core interrupt enable state |
| in_isr | input | 1 | Core is inside an interrupt routine |
| int_n | input | 1 | Interrupt pin, active low, asynchronous |
| ext_reset_n | input | 1 | Reset pin, active low, asynchronous |
| standby_n | input | 1 | Standby pin, active low, asynchronous |
| ale_tick | input | 1 | One-cycle pulse per address-latch strobe |
| osc_stable | input | 1 | Oscillator has settled |
| cpu_clk_en | output | 1 | Clock enable for core control logic |
| osc_stop_req | output | 1 | Request to stop the oscillator |
| float_grp | output | 10 | Per-group tri-state override, 1 = high impedance |
| wake_pulse | output | 1 | One-cycle wake event |
| wake_kind | output | 2 | 1 = reset to 0, 2 = interrupt to 3, 3 = resume |

## Verification
The bound checker checks these rules on every cycle:
- an oscillator-stop request never coexists with an enabled core clock;
- every wake pulse carries a legal kind, re-enables the clock and lasts one cycle;
- standby always floats every group;
- pin-driven vector wakes never happen before enough ALE pulses were seen in the qualifying state;
- a reset wake after an oscillator stop only follows a stable oscillator.

Only the bench scenarios can show the rest: the per-mode float masks, that opcodes are ignored while halted, that an early pin release clears the count, and the choice between vector and resume under the interrupt-enable and in-routine flags.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_HALT, ST_QUAL, ST_STBY} pstate_t;
  typedef enum logic {HK_GATE, HK_OSC} halt_kind_t;
  typedef enum logic [1:0] {FL_NONE, FL_PORTS, FL_ALL} float_t;

  localparam int GRP_N = 10;
  localparam int G_P1 = 0;
  localparam int G_P2H = 1;
  localparam int G_P2L = 2;
  localparam int G_BUS = 3;
  localparam int G_ALE = 4;
  localparam int G_PSEN = 5;
  localparam int G_PROG = 6;
  localparam int G_WR = 7;
  localparam int G_RD = 8;
  localparam int G_T0 = 9;

  localparam logic [1:0] WK_NONE = 2'd0;
  localparam logic [1:0] WK_RST = 2'd1;
  localparam logic [1:0] WK_IRQ = 2'd2;
  localparam logic [1:0] WK_RES = 2'd3;

  localparam logic [7:0] OP_GATE = 8'h01;
  localparam logic [7:0] OP_OSC = 8'h82;
  localparam logic [7:0] OP_FLT = 8'hA2;
  localparam logic [7:0] OP_FLTALL = 8'hC2;

  function automatic logic [GRP_N-1:0] float_mask(float_t m, logic ext, logic stby);
    logic [GRP_N-1:0] r;
    r = '0;
    if (stby) begin
      r = '1;
    end else if (m == FL_PORTS) begin
      r[G_P1] = 1'b1;
      r[G_P2H] = 1'b1;
      r[G_P2L] = !ext;
      r[G_BUS] = !ext;
    end else if (m == FL_ALL) begin
      r = '1;
      if (ext) begin
        r[G_P2L] = 1'b0;
        r[G_BUS] = 1'b0;
        r[G_ALE] = 1'b0;
        r[G_PSEN] = 1'b0;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pwr_decode.sv
module pwr_decode #(
  parameter logic [7:0] CANCEL_OP = 8'hE2
) (
  input  logic       instr_valid,
  input  logic [7:0] instr_byte,
  output logic       req_gate,
  output logic       req_osc,
  output logic       req_flt,
  output logic       req_fltall,
  output logic       req_cancel
);
  import pwr_pkg::*;

  always_comb begin
    req_gate   = instr_valid && (instr_byte == OP_GATE);
    req_osc    = instr_valid && (instr_byte == OP_OSC);
    req_flt    = instr_valid && (instr_byte == OP_FLT);
    req_fltall = instr_valid && (instr_byte == OP_FLTALL);
    req_cancel = instr_valid && (instr_byte == CANCEL_OP);
  end
endmodule

// File: rtl/pwr_ale_qual.sv
module pwr_ale_qual #(
  parameter int QUAL_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic ale_tick,
  output logic qualified
);
  localparam int CNT_W = $clog2(QUAL_N + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(QUAL_N);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !active) cnt_q <= '0;
    else if (ale_tick && cnt_q < LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign qualified = active && (cnt_q >= LIMIT);
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl #(
  parameter int         ALE_QUAL = 2,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] CANCEL_OP = 8'hE2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      instr_valid,
  input  logic [7:0]                instr_byte,
  input  logic                      ext_rom,
  input  logic                      int_en,
  input  logic                      in_isr,
  input  logic                      int_n,
  input  logic                      ext_reset_n,
  input  logic                      standby_n,
  input  logic                      ale_tick,
  input  logic                      osc_stable,
  output logic                      cpu_clk_en,
  output logic                      osc_stop_req,
  output logic [pwr_pkg::GRP_N-1:0] float_grp,
  output logic                      wake_pulse,
  output logic [1:0]                wake_kind
);
  import pwr_pkg::*;

  localparam int PIN_N = 3;

  logic [PIN_N-1:0] pins_s;
  logic s_int_n, s_rst_n, s_stby_n;

  pwr_sync #(.STAGES(SYNC_STAGES), .WIDTH(PIN_N)) u_sync (
    .clk(clk), .rst(rst),
    .d({standby_n, ext_reset_n, int_n}),
    .q(pins_s)
  );
  assign s_int_n  = pins_s[0];
  assign s_rst_n  = pins_s[1];
  assign s_stby_n = pins_s[2];

  logic req_gate, req_osc, req_flt, req_fltall, req_cancel;

  pwr_decode #(.CANCEL_OP(CANCEL_OP)) u_dec (
    .instr_valid(instr_valid), .instr_byte(instr_byte),
    .req_gate(req_gate), .req_osc(req_osc), .req_flt(req_flt),
    .req_fltall(req_fltall), .req_cancel(req_cancel)
  );

  pstate_t    state_q, state_n;
  halt_kind_t hk_q, hk_n;
  float_t     fl_q, fl_n;
  logic [1:0] wk_n;
  logic       wake_low, qualified;

  assign wake_low = !s_rst_n || !s_int_n;

  pwr_ale_qual #(.QUAL_N(ALE_QUAL)) u_qual (
    .clk(clk), .rst(rst),
    .active((state_q == ST_QUAL) && wake_low),
    .ale_tick(ale_tick),
    .qualified(qualified)
  );

  always_comb begin
    state_n = state_q;
    hk_n    = hk_q;
    fl_n    = fl_q;
    wk_n    = WK_NONE;
    case (state_q)
      ST_RUN: begin
        if (req_gate) begin
          state_n = ST_HALT;
          hk_n    = HK_GATE;
        end else if (req_osc) begin
          state_n = ST_HALT;
          hk_n    = HK_OSC;
        end else if (req_flt) begin
          fl_n = FL_PORTS;
        end else if (req_fltall) begin
          fl_n = FL_ALL;
        end else if (req_cancel) begin
          fl_n = FL_NONE;
        end
      end
      ST_HALT: begin
        if (wake_low) state_n = ST_QUAL;
      end
      ST_QUAL: begin
        if (!wake_low) begin
          state_n = ST_HALT;
        end else if (qualified) begin
          if (!s_rst_n) begin
            if (hk_q == HK_GATE || osc_stable) begin
              wk_n    = WK_RST;
              state_n = ST_RUN;
            end
          end else begin
            wk_n    = (int_en && !in_isr) ? WK_IRQ : WK_RES;
            state_n = ST_RUN;
          end
        end
      end
      ST_STBY: begin
        if (s_stby_n) begin
          if (wake_low) begin
            state_n = ST_QUAL;
          end else begin
            wk_n    = WK_RES;
            state_n = ST_RUN;
          end
        end
      end
      default: state_n = ST_RUN;
    endcase
    if (wake_low) fl_n = FL_NONE;
    if (!s_stby_n) begin
      state_n = ST_STBY;
      hk_n    = HK_OSC;
      wk_n    = WK_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_RUN;
      hk_q         <= HK_GATE;
      fl_q         <= FL_NONE;
      cpu_clk_en   <= 1'b1;
      osc_stop_req <= 1'b0;
      float_grp    <= '0;
      wake_pulse   <= 1'b0;
      wake_kind    <= WK_NONE;
    end else begin
      state_q      <= state_n;
      hk_q         <= hk_n;
      fl_q         <= fl_n;
      cpu_clk_en   <= (state_n == ST_RUN);
      osc_stop_req <= (state_n == ST_STBY) || (state_n == ST_HALT && hk_n == HK_OSC);
      float_grp    <= float_mask(fl_n, ext_rom, state_n == ST_STBY);
      wake_pulse   <= (wk_n != WK_NONE);
      wake_kind    <= wk_n;
    end
  end
endmodule

// File: rtl/pwr_wake_ctrl_chk.sv
module pwr_wake_ctrl_chk #(
  parameter int QUAL_N = 2,
  parameter int GRP_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             ale_tick,
  input logic             osc_stable,
  input logic             cpu_clk_en,
  input logic             osc_stop_req,
  input logic [GRP_W-1:0] float_grp,
  input logic             wake_pulse,
  input logic [1:0]       wake_kind,
  input pwr_pkg::pstate_t st,
  input pwr_pkg::halt_kind_t hk
);
  import pwr_pkg::*;

  logic [7:0] chk_cnt;

  always_ff @(posedge clk) begin
    if (rst || st != ST_QUAL) chk_cnt <= '0;
    else if (ale_tick && chk_cnt != 8'hFF) chk_cnt <= chk_cnt + 8'd1;
  end

  assert_osc_clk_excl_R2: assert property (@(posedge clk) disable iff (rst)
    osc_stop_req |-> !cpu_clk_en);

  assert_wake_kind_legal_R8: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> (wake_kind != WK_NONE));

  assert_wake_clk_on_R8: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> cpu_clk_en);

  assert_wake_single_R8: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |=> !wake_pulse);

  assert_stby_all_float_R10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_STBY) |-> (float_grp == {GRP_W{1'b1}} && osc_stop_req && !cpu_clk_en));

  assert_wake_qualified_R7: assert property (@(posedge clk) disable iff (rst)
    (wake_pulse && wake_kind != WK_RES) |-> (chk_cnt >= 8'(QUAL_N)));

  assert_rst_wake_osc_R9: assert property (@(posedge clk) disable iff (rst)
    (wake_pulse && wake_kind == WK_RST && hk == HK_OSC) |-> $past(osc_stable));
endmodule

bind pwr_wake_ctrl pwr_wake_ctrl_chk #(.QUAL_N(ALE_QUAL), .GRP_W(pwr_pkg::GRP_N)) u_chk (
  .clk(clk), .rst(rst), .ale_tick(ale_tick), .osc_stable(osc_stable),
  .cpu_clk_en(cpu_clk_en), .osc_stop_req(osc_stop_req), .float_grp(float_grp),
  .wake_pulse(wake_pulse), .wake_kind(wake_kind), .st(state_q), .hk(hk_q)
);

// File: tb/tb_pwr_wake_ctrl.sv
module tb_pwr_wake_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic instr_valid = 1'b0;
  logic [7:0] instr_byte = 8'h00;
  logic ext_rom = 1'b0, int_en = 1'b0, in_isr = 1'b0;
  logic int_n = 1'b1, ext_reset_n = 1'b1, standby_n = 1'b1;
  logic ale_tick = 1'b0, osc_stable = 1'b1;
  logic cpu_clk_en, osc_stop_req, wake_pulse;
  logic [9:0] float_grp;
  logic [1:0] wake_kind;

  int checks = 0, fails = 0, wakes = 0;
  logic [1:0] last_kind = 2'd0;

  always #5 clk = ~clk;

  pwr_wake_ctrl dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_byte(instr_byte),
    .ext_rom(ext_rom), .int_en(int_en), .in_isr(in_isr), .int_n(int_n),
    .ext_reset_n(ext_reset_n), .standby_n(standby_n), .ale_tick(ale_tick),
    .osc_stable(osc_stable), .cpu_clk_en(cpu_clk_en), .osc_stop_req(osc_stop_req),
    .float_grp(float_grp), .wake_pulse(wake_pulse), .wake_kind(wake_kind)
  );

  always @(negedge clk) begin
    if (wake_pulse) begin
      wakes++;
      last_kind = wake_kind;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic op(logic [7:0] b);
    @(negedge clk);
    instr_valid = 1'b1;
    instr_byte = b;
    @(negedge clk);
    instr_valid = 1'b0;
    instr_byte = 8'h00;
  endtask

  task automatic ale(int n);
    repeat (n) begin
      @(negedge clk) ale_tick = 1'b1;
      @(negedge clk) ale_tick = 1'b0;
    end
  endtask

  // {pre opcode, opcode, ext_rom, expected float_grp}
  localparam logic [26:0] VEC [6] = '{
    {8'hA2, 8'h00, 1'b0, 10'h00F},
    {8'h00, 8'hA2, 1'b1, 10'h003},
    {8'h00, 8'hC2, 1'b0, 10'h3FF},
    {8'h00, 8'hC2, 1'b1, 10'h3C3},
    {8'hC2, 8'hE2, 1'b0, 10'h000},
    {8'hA2, 8'hC2, 1'b1, 10'h3C3}
  };

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int w;
    idle(3);
    rst = 1'b0;
    idle(1);
    check("R1 clk_en", cpu_clk_en, 1);
    check("R1 osc_stop", osc_stop_req, 0);
    check("R1 float", float_grp, 0);
    check("R1 wake", wake_pulse, 0);

    for (int i = 0; i < 6; i++) begin
      ext_rom = 1'b0;
      op(8'hE2);
      ext_rom = VEC[i][10];
      op(VEC[i][26:19]);
      op(VEC[i][18:11]);
      check((i < 2) ? "R4 float mask" : (i == 4) ? "R6 cancel" : "R5 float mask",
            float_grp, VEC[i][9:0]);
    end
    ext_rom = 1'b0;
    op(8'hE2);

    // gate halt, ignored opcodes, early release, IRQ wake
    op(8'h01);
    check("R2 gate clk_en", cpu_clk_en, 0);
    check("R2 gate osc", osc_stop_req, 0);
    op(8'hA2);
    check("R3 float ignored", float_grp, 0);
    check("R3 still halted", cpu_clk_en, 0);
    w = wakes;
    int_n = 1'b0; idle(4); ale(1); int_n = 1'b1; idle(5);
    check("R7 early release no wake", wakes, w);
    check("R7 still halted", cpu_clk_en, 0);
    int_en = 1'b1; in_isr = 1'b0;
    int_n = 1'b0; idle(4); ale(1); idle(2);
    check("R7 count restarted", wakes, w);
    ale(1); idle(3);
    check("R8 irq wake", wakes, w + 1);
    check("R8 irq kind", last_kind, 2);
    check("R8 clk back", cpu_clk_en, 1);
    int_n = 1'b1; idle(4);

    // resume paths
    in_isr = 1'b1;
    op(8'h01); int_n = 1'b0; idle(4); ale(2); idle(3);
    check("R8 in routine resumes", last_kind, 3);
    int_n = 1'b1; in_isr = 1'b0; int_en = 1'b0; idle(4);
    op(8'h01); int_n = 1'b0; idle(4); ale(2); idle(3);
    check("R8 disabled resumes", last_kind, 3);
    int_n = 1'b1; idle(4);

    // float cleared by pins
    op(8'hA2);
    check("R4 float set", float_grp, 10'h00F);
    int_n = 1'b0; idle(4);
    check("R6 int clears float", float_grp, 0);
    int_n = 1'b1; idle(4);
    op(8'hC2); ext_reset_n = 1'b0; idle(4);
    check("R6 reset clears float", float_grp, 0);
    ext_reset_n = 1'b1; idle(4);

    // oscillator-stop halt with reset wake
    osc_stable = 1'b0;
    op(8'h82);
    check("R2 osc stop", osc_stop_req, 1);
    check("R2 osc clk_en", cpu_clk_en, 0);
    w = wakes;
    ext_reset_n = 1'b0; idle(4);
    check("R7 osc restarted", osc_stop_req, 0);
    ale(3); idle(3);
    check("R9 waits for osc", wakes, w);
    osc_stable = 1'b1; idle(3);
    check("R9 reset kind", last_kind, 1);
    check("R9 reset wake", wakes, w + 1);
    ext_reset_n = 1'b1; idle(4);

    // reset over interrupt
    int_en = 1'b1;
    op(8'h01); int_n = 1'b0; ext_reset_n = 1'b0; idle(4); ale(2); idle(3);
    check("R9 reset priority", last_kind, 1);
    int_n = 1'b1; ext_reset_n = 1'b1; idle(4);

    // standby
    w = wakes;
    standby_n = 1'b0; idle(5);
    check("R10 standby float", float_grp, 10'h3FF);
    check("R10 standby osc", osc_stop_req, 1);
    check("R10 standby clk", cpu_clk_en, 0);
    standby_n = 1'b1; idle(5);
    check("R10 standby resume", wakes, w + 1);
    check("R10 resume kind", last_kind, 3);
    check("R10 clk back", cpu_clk_en, 1);

    w = wakes;
    standby_n = 1'b0; idle(5);
    ext_reset_n = 1'b0; idle(3);
    standby_n = 1'b1; idle(5);
    check("R11 no wake before qual", wakes, w);
    ale(2); idle(3);
    check("R11 qualified reset", wakes, w + 1);
    check("R11 kind", last_kind, 1);
    ext_reset_n = 1'b1; idle(4);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule